// File: doc/BRIEF.md
# Segmented Virtual Address Generator

This block forms the global virtual address used by load and store instructions in a machine whose virtual memory is split into spaces. It keeps a file of eight space registers, each holding a space identifier, and on every valid access it concatenates one of those identifiers with a 32-bit byte offset. The offset is the base register plus either a sign-extended displacement or an index register value. The sum wraps within 32 bits, and any carry out is discarded. It never reaches the space identifier.

A 2-bit space-select field from the instruction picks the addressing form. A zero value gives short-pointer addressing: the two most significant bits of the base register choose one of registers 4 to 7. A non-zero value gives long-pointer addressing: the field names register 1, 2 or 3 directly, and the whole 32-bit offset lies within that space. Register 0 can be written and read back but no address computation ever selects it. A write port updates the space registers, and a separate read port returns the value of any register. The address output is registered and appears one cycle after a valid strobe.

Top module: `seg_vaddr_gen`

## Requirements
- R1: While reset is asserted and after it is released, vaValid is 0, vaOut is 0 and every space register reads back 0 until it is written.
- R2: With srWrEn high at a clock edge, register srWrAddr (any of 0 to 7) takes srWrData; srRdData shows the register chosen by srRdAddr, combinationally.
- R3: When spaceSel is 2'b00 the space identifier comes from register 4 + baseVal[31:30] (00 to reg 4, 01 to reg 5, 10 to reg 6, 11 to reg 7).
- R4: When spaceSel is 1, 2 or 3 the space identifier comes from the register of that number, and baseVal[31:30] does not affect which register is used.
- R5: With useIdx = 0 the offset is baseVal plus dispVal sign-extended from DISP_W bits (default 14) to 32 bits.
- R6: With useIdx = 1 the offset is baseVal plus idxVal.
- R7: The offset sum is taken modulo 2^32; a carry out of bit 31 leaves the space identifier unchanged.
- R8: vaValid is high in exactly the cycle after a cycle with reqValid high; vaOut changes only after such a cycle and otherwise holds its value.
- R9: An access in the same cycle as a write to the register it selects uses the value held before that write; the next access uses the new value.
- R10: Register 0 is never the source of the space identifier, whatever spaceSel and baseVal are.
- R11: vaOut carries the space identifier in its top SID_W bits and the 32-bit offset in bits 31:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access strobe; inputs are captured when high |
| baseVal | input | 32 | Base register value |
| dispVal | input | DISP_W | Signed displacement |
| idxVal | input | 32 | Index register value |
| useIdx | input | 1 | 1 adds the index, 0 adds the displacement |
| spaceSel | input | 2 | Space-select field; 0 short form, else long form register number |
| srWrEn | input | 1 | Space register write enable |
| srWrAddr | input | 3 | Space register written |
| srWrData | input | SID_W | Value written |
| srRdAddr | input | 3 | Space register read back |
| srRdData | output | SID_W | Value of register srRdAddr |
| vaValid | output | 1 | Address valid, one cycle after reqValid |
| vaOut | output | SID_W+32 | Space identifier concatenated with byte offset |

## Verification
Every short-form base quadrant is driven with each space register holding a distinct identifier. This shows that the top base bits really steer the choice, and that register 0's unique value never leaks out. Long-form accesses use a base with both top bits set, so a wrong mode decode would pick register 7 and not the named register. A negative displacement, an index addition and a sum that overflows 32 bits separate sign extension, operand choice and carry isolation. A write that coincides with an access to the same register separates old-value from new-value forwarding. An idle cycle with changed inputs shows that the registered output holds.

// File: rtl/seg_vaddr_pkg.sv
package seg_vaddr_pkg;
  localparam int NUM_SR   = 8;
  localparam int SR_IDX_W = $clog2(NUM_SR);
  localparam int OFS_W    = 32;

  // strobes from control to datapath
  typedef struct packed {
    logic                capture;
    logic                addIndex;
    logic [SR_IDX_W-1:0] srIdx;
  } segStrobes_t;
endpackage

// File: rtl/seg_vaddr_ctrl.sv
module seg_vaddr_ctrl
  import seg_vaddr_pkg::*;
#(
  parameter int OperandMode = 2  // 0 displacement only, 1 index only, 2 per access
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [1:0]  spaceSel,
  input  logic [1:0]  baseTop,
  input  logic        useIdx,
  output segStrobes_t strb
);
  logic addIdx;

  generate
    if (OperandMode == 0) begin : g_disp
      assign addIdx = 1'b0;
    end else if (OperandMode == 1) begin : g_idx
      assign addIdx = 1'b1;
    end else begin : g_sel
      assign addIdx = useIdx;
    end
  endgenerate

  always_comb begin
    strb.capture  = reqValid;
    strb.addIndex = addIdx;
    if (spaceSel == 2'b00) strb.srIdx = {1'b1, baseTop};
    else                   strb.srIdx = {1'b0, spaceSel};
  end

  assert_short_upper_R3: assert property (@(posedge clk) disable iff (!rstN)
    (spaceSel == 2'b00) |-> (strb.srIdx[2] && strb.srIdx[1:0] == baseTop));

  assert_long_lower_R4: assert property (@(posedge clk) disable iff (!rstN)
    (spaceSel != 2'b00) |-> (!strb.srIdx[2] && strb.srIdx[1:0] == spaceSel));
endmodule

// File: rtl/seg_vaddr_dp.sv
module seg_vaddr_dp
  import seg_vaddr_pkg::*;
#(
  parameter int SID_W  = 32,
  parameter int DISP_W = 14
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  segStrobes_t           strb,
  input  logic [OFS_W-1:0]      baseVal,
  input  logic [DISP_W-1:0]     dispVal,
  input  logic [OFS_W-1:0]      idxVal,
  input  logic                  srWrEn,
  input  logic [SR_IDX_W-1:0]   srWrAddr,
  input  logic [SID_W-1:0]      srWrData,
  input  logic [SR_IDX_W-1:0]   srRdAddr,
  output logic [SID_W-1:0]      srRdData,
  output logic                  vaValid,
  output logic [SID_W+OFS_W-1:0] vaOut
);
  localparam int EXT_W = OFS_W - DISP_W;

  logic [SID_W-1:0] spaceReg [NUM_SR];
  logic [OFS_W-1:0] dispExt;
  logic [OFS_W-1:0] addend;
  logic [OFS_W-1:0] offsetSum;
  logic [SID_W-1:0] selSid;

  assign dispExt   = {{EXT_W{dispVal[DISP_W-1]}}, dispVal};
  assign addend    = strb.addIndex ? idxVal : dispExt;
  assign offsetSum = baseVal + addend;       // 32-bit wrap, carry dropped
  assign selSid    = spaceReg[strb.srIdx];
  assign srRdData  = spaceReg[srRdAddr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SR; i++) spaceReg[i] <= '0;
    end else if (srWrEn) begin
      spaceReg[srWrAddr] <= srWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaValid <= 1'b0;
      vaOut   <= '0;
    end else begin
      vaValid <= strb.capture;
      if (strb.capture) vaOut <= {selSid, offsetSum};
    end
  end

  assert_sr_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    srWrEn |=> (spaceReg[$past(srWrAddr)] == $past(srWrData)));

  assert_never_reg0_R10: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |-> (strb.srIdx != '0));

  assert_valid_next_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> vaValid);

  assert_idle_low_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> !vaValid);

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> $stable(vaOut));
endmodule

// File: rtl/seg_vaddr_gen.sv
module seg_vaddr_gen
  import seg_vaddr_pkg::*;
#(
  parameter int SID_W       = 32,
  parameter int DISP_W      = 14,
  parameter int OperandMode = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic [31:0]            baseVal,
  input  logic [DISP_W-1:0]      dispVal,
  input  logic [31:0]            idxVal,
  input  logic                   useIdx,
  input  logic [1:0]             spaceSel,
  input  logic                   srWrEn,
  input  logic [2:0]             srWrAddr,
  input  logic [SID_W-1:0]       srWrData,
  input  logic [2:0]             srRdAddr,
  output logic [SID_W-1:0]       srRdData,
  output logic                   vaValid,
  output logic [SID_W+31:0]      vaOut
);
  segStrobes_t strb;

  seg_vaddr_ctrl #(.OperandMode(OperandMode)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .spaceSel (spaceSel),
    .baseTop  (baseVal[31:30]),
    .useIdx   (useIdx),
    .strb     (strb)
  );

  seg_vaddr_dp #(.SID_W(SID_W), .DISP_W(DISP_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .baseVal  (baseVal),
    .dispVal  (dispVal),
    .idxVal   (idxVal),
    .srWrEn   (srWrEn),
    .srWrAddr (srWrAddr),
    .srWrData (srWrData),
    .srRdAddr (srRdAddr),
    .srRdData (srRdData),
    .vaValid  (vaValid),
    .vaOut    (vaOut)
  );
endmodule

// File: tb/sim_seg_vaddr_gen.sv
module sim_seg_vaddr_gen;
  localparam int SID_W  = 32;
  localparam int DISP_W = 14;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic [31:0]       baseVal = '0;
  logic [DISP_W-1:0] dispVal = '0;
  logic [31:0]       idxVal = '0;
  logic              useIdx = 1'b0;
  logic [1:0]        spaceSel = '0;
  logic              srWrEn = 1'b0;
  logic [2:0]        srWrAddr = '0;
  logic [SID_W-1:0]  srWrData = '0;
  logic [2:0]        srRdAddr = '0;
  logic [SID_W-1:0]  srRdData;
  logic              vaValid;
  logic [SID_W+31:0] vaOut;

  int testCount = 0;
  int failCount = 0;
  logic [SID_W-1:0] model [8];
  logic [SID_W+31:0] lastVa;

  always #4 clk = ~clk;

  seg_vaddr_gen #(.SID_W(SID_W), .DISP_W(DISP_W)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .baseVal(baseVal),
    .dispVal(dispVal), .idxVal(idxVal), .useIdx(useIdx), .spaceSel(spaceSel),
    .srWrEn(srWrEn), .srWrAddr(srWrAddr), .srWrData(srWrData),
    .srRdAddr(srRdAddr), .srRdData(srRdData), .vaValid(vaValid), .vaOut(vaOut)
  );

  function automatic logic [SID_W-1:0] sidFor(int i);
    return 32'hA000_0000 + i * 32'h0011_0101;
  endfunction

  function automatic logic [31:0] sext(logic [DISP_W-1:0] d);
    return {{(32-DISP_W){d[DISP_W-1]}}, d};
  endfunction

  task automatic check(string tag, logic [SID_W+31:0] act, logic [SID_W+31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic writeSr(int addr, logic [SID_W-1:0] val);
    @(negedge clk);
    srWrEn = 1'b1; srWrAddr = 3'(addr); srWrData = val;
    @(posedge clk); #2;
    srWrEn = 1'b0;
    model[addr] = val;
  endtask

  // one access; returns observed address one cycle after the strobe
  task automatic access(string tag, logic [1:0] sel, logic [31:0] base,
                        logic [DISP_W-1:0] disp, logic [31:0] idx, logic ui,
                        int expReg);
    logic [31:0] ofs;
    ofs = base + (ui ? idx : sext(disp));
    @(negedge clk);
    reqValid = 1'b1; spaceSel = sel; baseVal = base; dispVal = disp;
    idxVal = idx; useIdx = ui;
    @(posedge clk); #2;
    reqValid = 1'b0;
    check({tag, " valid"}, {63'd0, vaValid}, 64'd1);
    check(tag, vaOut, {model[expReg], ofs});
    lastVa = vaOut;
  endtask

  task automatic testReset();
    srRdAddr = 3'd3;
    #1;
    check("R1 vaValid", {63'd0, vaValid}, 64'd0);
    check("R1 vaOut", vaOut, 64'd0);
    check("R1 sr3", {32'd0, srRdData}, 64'd0);
  endtask

  task automatic testWrites();
    for (int i = 0; i < 8; i++) writeSr(i, (i == 0) ? 32'hDEAD_BEEF : sidFor(i));
    for (int i = 0; i < 8; i++) begin
      srRdAddr = 3'(i); #1;
      check($sformatf("R2 readback %0d", i), {32'd0, srRdData}, {32'd0, model[i]});
    end
  endtask

  task automatic testShort();
    for (int q = 0; q < 4; q++) begin
      access($sformatf("R3 R11 short q%0d", q), 2'b00,
             {2'(q), 30'h0123_4560}, 14'h0010, 32'd0, 1'b0, 4 + q);
      check("R10 short", {32'd0, lastVa[63:32]} == {32'd0, model[0]} ? 64'd1 : 64'd0, 64'd0);
    end
  endtask

  task automatic testLong();
    for (int s = 1; s < 4; s++) begin
      access($sformatf("R4 long sel%0d", s), 2'(s), 32'hC000_1000,
             14'h0004, 32'd0, 1'b0, s);
      check("R10 long", {32'd0, lastVa[63:32]} == {32'd0, model[0]} ? 64'd1 : 64'd0, 64'd0);
    end
  endtask

  task automatic testOperands();
    access("R5 negative disp", 2'b00, 32'h4000_0000, 14'h3FFF, 32'hFFFF_FFFF, 1'b0, 5);
    check("R5 offset", {32'd0, lastVa[31:0]}, 64'h3FFF_FFFF);
    access("R5 min disp", 2'b01, 32'h0001_0000, 14'h2000, 32'd0, 1'b0, 1);
    check("R5 min offset", {32'd0, lastVa[31:0]}, 64'h0000_E000);
    access("R6 index add", 2'b10, 32'h1234_0000, 14'h1FFF, 32'h0000_5678, 1'b1, 2);
    check("R6 offset", {32'd0, lastVa[31:0]}, 64'h1234_5678);
  endtask

  task automatic testWrap();
    access("R7 wrap index", 2'b10, 32'hFFFF_FFF0, 14'h0, 32'h0000_0020, 1'b1, 2);
    check("R7 sid kept", {32'd0, lastVa[63:32]}, {32'd0, model[2]});
    check("R7 offset", {32'd0, lastVa[31:0]}, 64'h0000_0010);
    access("R7 wrap short", 2'b00, 32'hFFFF_FFFF, 14'h0001, 32'd0, 1'b0, 7);
  endtask

  task automatic testHold();
    logic [SID_W+31:0] held;
    access("R8 setup", 2'b11, 32'h0000_0100, 14'h0002, 32'd0, 1'b0, 3);
    held = lastVa;
    @(negedge clk);
    baseVal = 32'h5555_5555; spaceSel = 2'b01; dispVal = 14'h0AAA;
    @(posedge clk); #2;
    check("R8 idle valid", {63'd0, vaValid}, 64'd0);
    check("R8 idle hold", vaOut, held);
    @(posedge clk); #2;
    check("R8 still held", vaOut, held);
  endtask

  task automatic testSameCycle();
    logic [SID_W-1:0] oldSid;
    oldSid = model[5];
    @(negedge clk);
    srWrEn = 1'b1; srWrAddr = 3'd5; srWrData = 32'h1357_9BDF;
    reqValid = 1'b1; spaceSel = 2'b00; baseVal = 32'h4000_0100;
    dispVal = 14'h0; useIdx = 1'b0;
    @(posedge clk); #2;
    srWrEn = 1'b0; reqValid = 1'b0;
    model[5] = 32'h1357_9BDF;
    check("R9 old value", vaOut, {oldSid, 32'h4000_0100});
    access("R9 new value", 2'b00, 32'h4000_0100, 14'h0, 32'd0, 1'b0, 5);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    testReset();
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #2;
    check("R1 after release", {63'd0, vaValid}, 64'd0);
    testWrites();
    testShort();
    testLong();
    testOperands();
    testWrap();
    testHold();
    testSameCycle();
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    #(8 * 200000);
    testCount++;
    failCount++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule